// File: doc/BRIEF.md
# Dual-Clock FIFO Status Flag Generator

This block produces the occupancy flags for an asynchronous FIFO whose writer and reader run on unrelated clocks. It keeps a write pointer in the write-clock domain and a read pointer in the read-clock domain. Each pointer is Gray-coded and passed to the other domain through two flip-flop stages. Each domain then works out its own view of the fill level and drives its flags from it. The storage array sits outside: it is addressed through `wr_addr` and `rd_addr`. It writes when `wr_valid && in_ready` and reads when `out_valid && out_ready`.

All four flags are low-true in the sense of "condition present". `in_ready` LOW means full. `out_valid` LOW means nothing can be read. `almost_full_n` and `almost_empty_n` go LOW when their condition holds.

The write side is a valid/ready handshake. A beat is taken on a `wclk` edge only when both `wr_valid` and `in_ready` are high. A writer that holds `wr_valid` against a low `in_ready` is simply held off, and nothing is lost or counted. The read side works the same way with `out_valid`/`out_ready` on `rclk`. The word handed out on that edge counts as gone from storage from that edge on.

The two almost-thresholds are offset registers clocked by `wclk`. They load parameter defaults at reset and can be rewritten by the host through `cfg_we`. The host should change them only while the FIFO is idle, because the read side uses the empty-side offset without a crossing stage.

Top module: `afifo_flags`

## Requirements
- R1: While `rst_n` is low and after it is released with no traffic, `out_valid`=0, `almost_empty_n`=0, `in_ready`=1 and `almost_full_n`=1. Reset loads both offsets from `AE_DEFAULT`/`AF_DEFAULT`.
- R2: A write is taken on a `wclk` rising edge only when `wr_valid` and `in_ready` are both high. With `in_ready` low the write is ignored: the level does not change and `wr_addr` holds.
- R3: A read is taken on an `rclk` rising edge only when `out_ready` and `out_valid` are both high. With `out_valid` low the read is ignored and the level does not change.
- R4: Once settled, `in_ready` is low exactly when the FIFO holds `DEPTH` words.
- R5: After a write into an empty FIFO, `out_valid` is still low after the first `rclk` rising edge that follows the write. It is high after the second.
- R6: After a read from a full FIFO, `in_ready` is still low after the first `wclk` rising edge that follows the read. It is high after the second.
- R7: Once settled, `almost_empty_n` is low when the level is at most X (the empty-side offset) and high when the level is X+1 or more.
- R8: Once settled, `almost_full_n` is low when the level is at least `DEPTH`−Y (Y the full-side offset) and high when the level is `DEPTH`−Y−1 or less.
- R9: A read removes its word from the read-side level on the same `rclk` edge. `out_valid` and `almost_empty_n` reflect the lower level right after that edge.
- R10: On a `wclk` edge with `cfg_we` high, `cfg_data` is stored as X when `cfg_sel`=0, or as Y when `cfg_sel`=1. A later reset restores the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_valid | input | 1 | Writer offers a word |
| in_ready | output | 1 | High: a location is free (low = full) |
| almost_full_n | output | 1 | Low: level at or above DEPTH−Y |
| wr_addr | output | $clog2(DEPTH) | Storage address for the next write |
| cfg_we | input | 1 | Offset register write strobe (wclk) |
| cfg_sel | input | 1 | 0 selects X (empty side), 1 selects Y (full side) |
| cfg_data | input | $clog2(DEPTH) | Offset value to store |
| out_ready | input | 1 | Reader takes a word |
| out_valid | output | 1 | High: a word is available (low = empty) |
| almost_empty_n | output | 1 | Low: level at or below X |
| rd_addr | output | $clog2(DEPTH) | Storage address of the word being read |

## Verification
The bench measures the crossing latency edge by edge in both directions. A design that compared unsynchronized pointers would raise `out_valid` or `in_ready` one edge early. A design with an extra stage would raise them one edge late. It pushes past full and pops past empty to catch pointers that wrap instead of holding. It then probes both thresholds exactly at X/X+1 and DEPTH−Y−1/DEPTH−Y, where an off-by-one compare flips a flag one word early. It also checks that the local side sees a read at once, and that a reset after reprogramming brings the default offsets back.

// File: rtl/afifo_flags_pkg.sv
package afifo_flags_pkg;
  // which offset register a configuration write targets
  typedef enum logic {
    OFS_EMPTY_SIDE = 1'b0,
    OFS_FULL_SIDE  = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/afifo_ptr.sv
// Binary/Gray pointer pair; both registered so the Gray copy never glitches.
module afifo_ptr #(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [PW-1:0] bin,
  output logic [PW-1:0] gray
);
  logic [PW-1:0] bin_nx;
  assign bin_nx = bin + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin  <= '0;
      gray <= '0;
    end else if (inc) begin
      bin  <= bin_nx;
      gray <= bin_nx ^ (bin_nx >> 1);
    end
  end

  AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gray ^ $past(gray))); // R5
endmodule

// File: rtl/afifo_sync2.sv
// Two-stage synchronizer for a Gray-coded pointer.
module afifo_sync2 #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/afifo_g2b.sv
// Gray to binary: each bit is the XOR of all Gray bits at or above it.
module afifo_g2b #(
  parameter int W = 9
) (
  input  logic [W-1:0] g,
  output logic [W-1:0] b
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b[i] = ^g[W-1:i];
  end
endmodule

// File: rtl/afifo_ofs_regs.sv
// Threshold offsets, write-clock domain, preset on reset.
module afifo_ofs_regs
  import afifo_flags_pkg::*;
#(
  parameter int AW         = 8,
  parameter int AE_DEFAULT = 8,
  parameter int AF_DEFAULT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel,
  input  logic [AW-1:0] data,
  output logic [AW-1:0] ae_ofs,
  output logic [AW-1:0] af_ofs
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_ofs <= AW'(AE_DEFAULT);
      af_ofs <= AW'(AF_DEFAULT);
    end else if (we) begin
      if (ofs_sel_e'(sel) == OFS_FULL_SIDE) af_ofs <= data;
      else                                  ae_ofs <= data;
    end
  end
endmodule

// File: rtl/afifo_flags.sv
module afifo_flags #(
  parameter int DEPTH      = 256,
  parameter int AE_DEFAULT = 8,
  parameter int AF_DEFAULT = 8,
  localparam int AW        = $clog2(DEPTH),
  localparam int PW        = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          in_ready,
  output logic          almost_full_n,
  output logic [AW-1:0] wr_addr,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          almost_empty_n,
  output logic [AW-1:0] rd_addr
);
  logic          wr_fire, rd_fire;
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] wgray_r, rgray_w, wbin_r, rbin_w;
  logic [PW-1:0] lvl_w, lvl_r, af_lim;
  logic [AW-1:0] ae_ofs, af_ofs;

  assign wr_fire = wr_valid & in_ready;
  assign rd_fire = out_ready & out_valid;

  // ---------------- write domain ----------------
  afifo_ptr #(.PW(PW)) u_wptr (
    .clk(wclk), .rst_n(rst_n), .inc(wr_fire), .bin(wbin), .gray(wgray)
  );
  afifo_sync2 #(.W(PW)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w)
  );
  afifo_g2b #(.W(PW)) u_r2w_bin (.g(rgray_w), .b(rbin_w));
  afifo_ofs_regs #(.AW(AW), .AE_DEFAULT(AE_DEFAULT), .AF_DEFAULT(AF_DEFAULT)) u_ofs (
    .clk(wclk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  assign lvl_w         = wbin - rbin_w;
  assign af_lim        = PW'(DEPTH) - {1'b0, af_ofs};
  assign in_ready      = (lvl_w != PW'(DEPTH));
  assign almost_full_n = (lvl_w < af_lim);
  assign wr_addr       = wbin[AW-1:0];

  // ---------------- read domain -----------------
  afifo_ptr #(.PW(PW)) u_rptr (
    .clk(rclk), .rst_n(rst_n), .inc(rd_fire), .bin(rbin), .gray(rgray)
  );
  afifo_sync2 #(.W(PW)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r)
  );
  afifo_g2b #(.W(PW)) u_w2r_bin (.g(wgray_r), .b(wbin_r));

  // the word just handed out is already subtracted (rbin moved on that edge)
  assign lvl_r          = wbin_r - rbin;
  assign out_valid      = (lvl_r != '0);
  assign almost_empty_n = (lvl_r > {1'b0, ae_ofs});
  assign rd_addr        = rbin[AW-1:0];

  // ---------------- assertions ------------------
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
    lvl_w <= PW'(DEPTH)); // R2
  AST_WR_HELD_OFF: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_valid && !in_ready) |=> (wr_addr == $past(wr_addr))); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
    lvl_r <= PW'(DEPTH)); // R3
  AST_EMPTY_IS_ALMOST: assert property (@(posedge rclk) disable iff (!rst_n)
    !out_valid |-> !almost_empty_n); // R7
  AST_FULL_IS_ALMOST: assert property (@(posedge wclk) disable iff (!rst_n)
    !in_ready |-> !almost_full_n); // R8
endmodule

// File: tb/afifo_flags_test.sv
module afifo_flags_test;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int XDEF  = 2;
  localparam int YDEF  = 3;

  typedef struct packed {
    logic [5:0] nw;
    logic [5:0] nr;
    logic [4:0] lvl;
  } step_t;

  // writes, reads, expected settled level (writes past full / reads past empty are dropped)
  localparam step_t STEPS [12] = '{
    '{6'd1,  6'd0,  5'd1},
    '{6'd2,  6'd0,  5'd3},
    '{6'd0,  6'd1,  5'd2},
    '{6'd10, 6'd0,  5'd12},
    '{6'd1,  6'd0,  5'd13},
    '{6'd10, 6'd0,  5'd16},
    '{6'd0,  6'd1,  5'd15},
    '{6'd0,  6'd2,  5'd13},
    '{6'd0,  6'd1,  5'd12},
    '{6'd0,  6'd20, 5'd0},
    '{6'd3,  6'd0,  5'd3},
    '{6'd0,  6'd3,  5'd0}
  };

  logic          wclk, rclk, rst_n;
  logic          wr_valid, in_ready, almost_full_n;
  logic [AW-1:0] wr_addr, rd_addr, cfg_data;
  logic          cfg_we, cfg_sel, out_ready, out_valid, almost_empty_n;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;

  afifo_flags #(.DEPTH(DEPTH), .AE_DEFAULT(XDEF), .AF_DEFAULT(YDEF)) uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_valid(wr_valid), .in_ready(in_ready), .almost_full_n(almost_full_n),
    .wr_addr(wr_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .out_ready(out_ready), .out_valid(out_valid), .almost_empty_n(almost_empty_n),
    .rd_addr(rd_addr)
  );

  // 100 MHz on both sides; read clock offset by 3 units
  initial begin wclk = 0; forever #5 wclk = ~wclk; end
  initial begin rclk = 0; #3; forever #5 rclk = ~rclk; end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // packed as {out_valid, almost_empty_n, in_ready, almost_full_n}
  task automatic chk_flags(input int lvl, input int x, input int y, input string req);
    int exp;
    exp = {lvl != 0, lvl > x, lvl != DEPTH, lvl < DEPTH - y};
    check(req, {out_valid, almost_empty_n, in_ready, almost_full_n}, exp);
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk) wr_valid = 1;
      @(posedge wclk); #1 wr_valid = 0;
    end
  endtask

  task automatic pop(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk) out_ready = 1;
      @(posedge rclk); #1 out_ready = 0;
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    #1;
  endtask

  task automatic cfg_write(input logic sel, input int val);
    @(negedge wclk);
    cfg_we = 1; cfg_sel = sel; cfg_data = AW'(val);
    @(posedge wclk); #1 cfg_we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge wclk);
    @(negedge wclk) rst_n = 1;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge wclk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wr_valid = 0; out_ready = 0; cfg_we = 0; cfg_sel = 0; cfg_data = '0;
    do_reset();
    chk_flags(0, XDEF, YDEF, "R1 reset flags");

    // table walk: R2 R3 R4 R7 R8
    for (int i = 0; i < 12; i++) begin
      push(int'(STEPS[i].nw));
      pop(int'(STEPS[i].nr));
      settle();
      chk_flags(int'(STEPS[i].lvl), XDEF, YDEF, "R2/R3/R4/R7/R8 table");
    end

    // R5: two read edges after a write into empty
    push(1);
    @(posedge rclk); #1 check("R5 first rclk edge", out_valid, 0);
    @(posedge rclk); #1 check("R5 second rclk edge", out_valid, 1);
    // R9: read of last word empties at once
    pop(1);
    check("R9 out_valid after last read", out_valid, 0);
    settle();

    // R9: almost-empty drops on the read edge itself (3 -> 2, X=2)
    push(3); settle();
    check("R9 ae before read", almost_empty_n, 1);
    pop(1);
    check("R9 ae right after read", almost_empty_n, 0);
    pop(2); settle();

    // R6: two write edges after a read from full
    push(DEPTH); settle();
    check("R6 full before read", in_ready, 0);
    pop(1);
    @(posedge wclk); #1 check("R6 first wclk edge", in_ready, 0);
    @(posedge wclk); #1 check("R6 second wclk edge", in_ready, 1);
    pop(DEPTH); settle();
    chk_flags(0, XDEF, YDEF, "R3 drained");

    // R10: reprogram X=5, Y=1 and probe both boundaries
    cfg_write(1'b0, 5);
    cfg_write(1'b1, 1);
    push(5);  settle(); chk_flags(5, 5, 1, "R10 X boundary low");
    push(1);  settle(); chk_flags(6, 5, 1, "R10 X boundary high");
    push(8);  settle(); chk_flags(14, 5, 1, "R10 Y boundary high");
    push(1);  settle(); chk_flags(15, 5, 1, "R10 Y boundary low");
    pop(DEPTH); settle();

    // R1/R10: reset brings defaults back
    do_reset();
    chk_flags(0, XDEF, YDEF, "R1 flags after second reset");
    push(3);  settle(); chk_flags(3, XDEF, YDEF, "R10 default X restored");
    push(10); settle(); chk_flags(13, XDEF, YDEF, "R10 default Y restored");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule